// File: doc/BRIEF.md
# Configurable UART Transmit Path

This block serializes bytes taken from a show-ahead transmit FIFO onto an asynchronous serial line. Each character is framed with a low start bit, five to eight data bits sent least significant bit first, an optional parity bit (even, odd or constant), and one or two high stop bits. The frame format is taken from an 8-bit line-control word. Separate control inputs enable the transmitter, select internal loopback, turn on an infrared pulse encoder, and choose what sets the transmit interrupt status.

All bit timing comes from an oversampling tick, `os_tick_i`, supplied by an external baud generator. One bit period is `OSR` ticks, and the default is 16. A send-break bit in the line-control word drives the line low once the current character has finished. Clearing the FIFO-enable bit produces a one-cycle flush request toward the FIFO. The transmit interrupt status is sticky. Depending on the mode, a FIFO level indication sets it, or the serializer drains completely with nothing left queued.

The sequencer has six states. IDLE moves to START when a character is loaded, or to BREAK when break is requested. START moves to DATA after one bit period. DATA moves to PARITY, or to STOP when parity is off, after the last data bit. PARITY moves to STOP. STOP ends in one of three ways after the last stop bit: it moves to START when another character is loaded back to back, to BREAK when break is set, or to IDLE otherwise. BREAK returns to IDLE when break clears.

Top module: `uart_tx_core`

## Requirements
- R1: After a low start bit, the data bits leave LSB first. The count is set by line-control bits 6:5: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Stop bits are high, and every bit lasts `OSR` oversampling ticks.
- R2: When line-control bit 1 (parity enable) is set, a parity bit follows the data. Bit 2 selects its sense: 1 makes the count of ones over data and parity even, and 0 makes it odd.
- R3: When line-control bit 7 (stick) and parity enable are both set, the parity bit is constant. It is 0 if bit 2 is set and 1 otherwise.
- R4: Line-control bit 3 selects two stop bits; when it is clear, one stop bit is sent.
- R5: A character is popped (`fifo_rd_o` high for one cycle) and started only when `ctl_en_i` and `ctl_txe_i` are both high, the FIFO is not empty and break is clear. Dropping either enable lets the current character finish and starts no new one.
- R6: The frame format is captured when a character starts. Line-control changes during a character do not alter that character.
- R7: While line-control bit 0 (break) is set, the line is driven low once the current character ends, and no character is popped. When the bit clears, the line returns to idle.
- R8: Clearing line-control bit 4 (FIFO enable) raises `fifo_flush_o` for exactly one cycle.
- R9: With `ctl_lbe_i` high, the encoded serial stream appears on `rx_int_o` and `txd_o` holds the idle level. With it low, `rx_int_o` follows `rxd_i`.
- R10: With `ctl_sir_i` high, each low bit is sent as one high pulse 3/16 of a bit period long (ticks 6 to 8 of 16), high bits are sent as low, and the idle line is low.
- R11: With `ctl_eot_i` low, `tx_lvl_hit_i` high in a cycle sets `ris_o` in the next cycle.
- R12: With `ctl_eot_i` high, `ris_o` is set only when the final stop bit of a character ends and the FIFO is empty. `tx_lvl_hit_i` is ignored in this mode.
- R13: `ris_clr_i` clears `ris_o`; a set condition in the same cycle wins.
- R14: After reset the transmitter is idle, `txd_o` is high (SIR off), `ris_o` is low and nothing is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en_i | input | 1 | Block enable |
| ctl_txe_i | input | 1 | Transmit enable |
| ctl_sir_i | input | 1 | Infrared pulse encoder enable |
| ctl_eot_i | input | 1 | Interrupt mode: 0 FIFO level, 1 serializer drained |
| ctl_lbe_i | input | 1 | Internal loopback enable |
| lcr_i | input | 8 | Line control: 7 stick, 6:5 length, 4 FIFO enable, 3 two stops, 2 even, 1 parity enable, 0 break |
| os_tick_i | input | 1 | Oversampling tick, OSR per bit |
| fifo_empty_i | input | 1 | Transmit FIFO empty |
| fifo_data_i | input | 8 | Head entry of the show-ahead FIFO |
| tx_lvl_hit_i | input | 1 | FIFO level threshold condition met |
| ris_clr_i | input | 1 | Clear the interrupt status |
| rxd_i | input | 1 | External receive pin |
| fifo_rd_o | output | 1 | Pop request |
| fifo_flush_o | output | 1 | Flush request |
| txd_o | output | 1 | Serial output pin |
| rx_int_o | output | 1 | Receive input toward the receiver |
| ris_o | output | 1 | Transmit raw interrupt status |

## Verification
The bench changes the frame format in the middle of a character. A design that does not capture the format at the start would shorten the character or add a parity bit to it. It drops the transmit enable while a character is on the line and checks that the character still completes whole and the queued one stays in the FIFO. A design that stops early, or one that pops anyway, would fail there. Break is raised mid-character to confirm it waits for the stop bit and never pops, and drained-mode interrupts are checked with a second character queued so that a premature set shows up. The infrared encoder is checked by counting pulses and high cycles, which exposes a wrong pulse width or an encoder that pulses on one bits.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_W = 8;
    localparam int MIN_BITS = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK
    } tx_state_e;

    typedef struct packed {
        logic       stick;
        logic [1:0] wlen;
        logic       stop2;
        logic       even;
        logic       par_en;
    } frame_cfg_t;

    // parity over the active data bits of one character
    function automatic logic calc_par(input frame_cfg_t c, input logic [DATA_W-1:0] d);
        logic x;
        x = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < MIN_BITS + int'(c.wlen)) x = x ^ d[i];
        end
        if (c.stick) return ~c.even;
        return c.even ? x : ~x;
    endfunction

endpackage

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_tx_pkg::*;
#(
    parameter int OSR = 16,
    localparam int SCW = $clog2(OSR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick_i,
    input  logic              go_ok_i,
    input  logic              brk_i,
    input  frame_cfg_t        cfg_i,
    input  logic              fifo_empty_i,
    input  logic [DATA_W-1:0] fifo_data_i,
    output logic              fifo_rd_o,
    output logic              line_o,
    output logic [SCW-1:0]    sc_o,
    output logic              done_o
);

    localparam logic [SCW-1:0] SC_LAST = SCW'(OSR - 1);
    localparam logic [2:0]     IDX_MIN = 3'(MIN_BITS - 1);

    tx_state_e         state_q, state_d;
    logic [SCW-1:0]    sc_q;
    logic [2:0]        bitn_q;
    logic [DATA_W-1:0] shreg_q;
    logic              par_q;
    logic [1:0]        wlen_q;
    logic              stop2_q;
    logic              pen_q;
    logic              load;
    logic              bit_end;
    logic              can_load;
    logic [2:0]        last_idx;

    assign bit_end  = os_tick_i && (sc_q == SC_LAST);
    assign can_load = go_ok_i && !fifo_empty_i && !brk_i;
    assign last_idx = IDX_MIN + {1'b0, wlen_q};

    // next-state logic
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (brk_i) begin
                    state_d = ST_BRK;
                end else if (can_load) begin
                    load    = 1'b1;
                    state_d = ST_START;
                end
            end
            ST_START: if (bit_end) state_d = ST_DATA;
            ST_DATA: begin
                if (bit_end && bitn_q == last_idx) state_d = pen_q ? ST_PAR : ST_STOP;
            end
            ST_PAR: if (bit_end) state_d = ST_STOP;
            ST_STOP: begin
                if (bit_end && bitn_q == {2'b00, stop2_q}) begin
                    done_o = fifo_empty_i;
                    if (brk_i) begin
                        state_d = ST_BRK;
                    end else if (can_load) begin
                        load    = 1'b1;
                        state_d = ST_START;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_BRK: if (!brk_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sc_q    <= '0;
            bitn_q  <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
            wlen_q  <= '0;
            stop2_q <= 1'b0;
            pen_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                sc_q    <= '0;
                shreg_q <= fifo_data_i;
                par_q   <= calc_par(cfg_i, fifo_data_i);
                wlen_q  <= cfg_i.wlen;
                stop2_q <= cfg_i.stop2;
                pen_q   <= cfg_i.par_en;
            end else begin
                if (state_q == ST_IDLE) begin
                    sc_q <= '0;
                end else if (os_tick_i) begin
                    sc_q <= (sc_q == SC_LAST) ? '0 : sc_q + 1'b1;
                end
                if (bit_end && state_q == ST_DATA) shreg_q <= {1'b0, shreg_q[DATA_W-1:1]};
            end
            if (state_d != state_q) begin
                bitn_q <= '0;
            end else if (bit_end && (state_q == ST_DATA || state_q == ST_STOP)) begin
                bitn_q <= bitn_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        fifo_rd_o = load;
        sc_o      = sc_q;
        unique case (state_q)
            ST_IDLE:  line_o = 1'b1;
            ST_START: line_o = 1'b0;
            ST_DATA:  line_o = shreg_q[0];
            ST_PAR:   line_o = par_q;
            ST_STOP:  line_o = 1'b1;
            ST_BRK:   line_o = 1'b0;
            default:  line_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_line.sv
module uart_tx_line #(
    parameter int OSR = 16,
    localparam int SCW = $clog2(OSR),
    localparam int PW  = (3 * OSR) / 16,
    localparam int P_LO = (OSR - PW) / 2,
    localparam int P_HI = P_LO + PW - 1
) (
    input  logic           line_i,
    input  logic [SCW-1:0] sc_i,
    input  logic           sir_en_i,
    input  logic           lbe_i,
    input  logic           rxd_i,
    output logic           txd_o,
    output logic           rx_int_o
);

    logic in_win;
    logic enc;

    assign in_win = (int'(sc_i) >= P_LO) && (int'(sc_i) <= P_HI);

    always_comb begin
        enc      = sir_en_i ? (!line_i && in_win) : line_i;
        txd_o    = lbe_i ? !sir_en_i : enc;
        rx_int_o = lbe_i ? enc : rxd_i;
    end

endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic eot_mode_i,
    input  logic lvl_hit_i,
    input  logic drained_i,
    input  logic clr_i,
    input  logic fen_i,
    output logic ris_o,
    output logic flush_o
);

    logic ris_q;
    logic fen_q;
    logic set;

    assign set     = eot_mode_i ? drained_i : lvl_hit_i;
    assign flush_o = fen_q && !fen_i;
    assign ris_o   = ris_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ris_q <= 1'b0;
            fen_q <= 1'b0;
        end else begin
            ris_q <= set || (ris_q && !clr_i);
            fen_q <= fen_i;
        end
    end

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_en_i,
    input  logic              ctl_txe_i,
    input  logic              ctl_sir_i,
    input  logic              ctl_eot_i,
    input  logic              ctl_lbe_i,
    input  logic [7:0]        lcr_i,
    input  logic              os_tick_i,
    input  logic              fifo_empty_i,
    input  logic [DATA_W-1:0] fifo_data_i,
    input  logic              tx_lvl_hit_i,
    input  logic              ris_clr_i,
    input  logic              rxd_i,
    output logic              fifo_rd_o,
    output logic              fifo_flush_o,
    output logic              txd_o,
    output logic              rx_int_o,
    output logic              ris_o
);

    localparam int SCW = $clog2(OSR);

    frame_cfg_t     cfg;
    logic           line;
    logic [SCW-1:0] sc;
    logic           drained;

    assign cfg = '{stick: lcr_i[7], wlen: lcr_i[6:5], stop2: lcr_i[3],
                   even: lcr_i[2], par_en: lcr_i[1]};

    uart_tx_fsm #(.OSR(OSR)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .os_tick_i    (os_tick_i),
        .go_ok_i      (ctl_en_i && ctl_txe_i),
        .brk_i        (lcr_i[0]),
        .cfg_i        (cfg),
        .fifo_empty_i (fifo_empty_i),
        .fifo_data_i  (fifo_data_i),
        .fifo_rd_o    (fifo_rd_o),
        .line_o       (line),
        .sc_o         (sc),
        .done_o       (drained)
    );

    uart_tx_line #(.OSR(OSR)) u_line (
        .line_i   (line),
        .sc_i     (sc),
        .sir_en_i (ctl_sir_i),
        .lbe_i    (ctl_lbe_i),
        .rxd_i    (rxd_i),
        .txd_o    (txd_o),
        .rx_int_o (rx_int_o)
    );

    uart_tx_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .eot_mode_i (ctl_eot_i),
        .lvl_hit_i  (tx_lvl_hit_i),
        .drained_i  (drained),
        .clr_i      (ris_clr_i),
        .fen_i      (lcr_i[4]),
        .ris_o      (ris_o),
        .flush_o    (fifo_flush_o)
    );

endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk (
    input logic clk,
    input logic rst_n,
    input logic ctl_en_i,
    input logic ctl_txe_i,
    input logic ctl_sir_i,
    input logic ctl_eot_i,
    input logic ctl_lbe_i,
    input logic brk_i,
    input logic fen_i,
    input logic fifo_empty_i,
    input logic tx_lvl_hit_i,
    input logic fifo_rd_o,
    input logic fifo_flush_o,
    input logic txd_o,
    input logic ris_o
);

    // R5
    pop_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |-> (ctl_en_i && ctl_txe_i && !fifo_empty_i && !brk_i));

    // R8
    flush_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush_o |-> (!fen_i && $past(fen_i)));

    // R9
    loop_pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_lbe_i |-> (txd_o == !ctl_sir_i));

    // R10
    sir_pulse_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_sir_i && !ctl_lbe_i && $rose(txd_o)) |=> txd_o);

    // R11
    lvl_sets_ris_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_eot_i && tx_lvl_hit_i) |=> ris_o);

    // R12
    drain_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_eot_i && $past(ctl_eot_i) && $rose(ris_o)) |-> $past(fifo_empty_i));

endmodule

bind uart_tx_core uart_tx_core_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_en_i     (ctl_en_i),
    .ctl_txe_i    (ctl_txe_i),
    .ctl_sir_i    (ctl_sir_i),
    .ctl_eot_i    (ctl_eot_i),
    .ctl_lbe_i    (ctl_lbe_i),
    .brk_i        (lcr_i[0]),
    .fen_i        (lcr_i[4]),
    .fifo_empty_i (fifo_empty_i),
    .tx_lvl_hit_i (tx_lvl_hit_i),
    .fifo_rd_o    (fifo_rd_o),
    .fifo_flush_o (fifo_flush_o),
    .txd_o        (txd_o),
    .ris_o        (ris_o)
);

// File: tb/uart_tx_core_tb_top.sv
`timescale 1ns/1ps
module uart_tx_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int OS_DIV     = 2;
    localparam int WDOG       = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_en_i = 1'b0, ctl_txe_i = 1'b0, ctl_sir_i = 1'b0, ctl_eot_i = 1'b0, ctl_lbe_i = 1'b0;
    logic [7:0] lcr_i = 8'h00;
    logic os_tick_i = 1'b0;
    logic fifo_empty_i;
    logic [7:0] fifo_data_i;
    logic tx_lvl_hit_i = 1'b0, ris_clr_i = 1'b0, rxd_i = 1'b1;
    logic fifo_rd_o, fifo_flush_o, txd_o, rx_int_o, ris_o;

    int checks = 0;
    int fails = 0;

    // frame configuration as seen by the bench
    logic c_stick = 0, c_fen = 1, c_stp2 = 0, c_eps = 0, c_pen = 0, c_brk = 0;
    logic [1:0] c_wlen = 2'd3;

    // FIFO model
    logic [7:0] mem [64];
    int wp = 0;
    int rp = 0;
    assign fifo_empty_i = (wp == rp);
    assign fifo_data_i  = mem[rp[5:0]];

    always @(posedge clk) begin
        if (fifo_flush_o) rp <= wp;
        else if (fifo_rd_o) rp <= rp + 1;
    end

    // monitors
    bit mon_en = 0;
    int hi_cnt = 0, rise_cnt = 0, low_cnt = 0, flush_cnt = 0;
    logic prev_txd = 1'b1;
    always @(negedge clk) begin
        if (mon_en) begin
            if (txd_o) hi_cnt++;
            else low_cnt++;
            if (txd_o && !prev_txd) rise_cnt++;
        end
        if (fifo_flush_o) flush_cnt++;
        prev_txd = txd_o;
    end

    uart_tx_core #(.OSR(16)) dut_i (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            #1 os_tick_i = ~os_tick_i;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply_lcr();
        lcr_i = {c_stick, c_wlen, c_fen, c_stp2, c_eps, c_pen, c_brk};
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        mem[wp[5:0]] = d;
        wp++;
    endtask

    task automatic wait_ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(negedge clk);
            if (os_tick_i) k++;
        end
    endtask

    function automatic logic line_sel(input bit use_rx);
        return use_rx ? rx_int_o : txd_o;
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input logic [1:0] wl, input logic st, input logic ev);
        logic x = 1'b0;
        if (st) return ~ev;
        for (int i = 0; i < 5 + int'(wl); i++) x ^= d[i];
        return ev ? x : ~x;
    endfunction

    task automatic frame_check(input logic [7:0] d, input bit use_rx, input logic [1:0] wl,
                               input logic pe, input logic s2, input logic st, input logic ev,
                               input string req);
        bit found = 0;
        bit stop_ok = 1;
        logic [7:0] got = '0;
        logic [7:0] msk;
        logic p = 1'b0;
        int nb = 5 + int'(wl);
        for (int t = 0; t < 4000 && !found; t++) begin
            @(negedge clk);
            if (line_sel(use_rx) == 1'b0) found = 1;
        end
        chk(found, req, "start bit seen", int'(found), 1);
        if (!found) return;
        wait_ticks(8);
        for (int i = 0; i < nb; i++) begin
            wait_ticks(16);
            got[i] = line_sel(use_rx);
        end
        if (pe) begin
            wait_ticks(16);
            p = line_sel(use_rx);
        end
        for (int i = 0; i < (s2 ? 2 : 1); i++) begin
            wait_ticks(16);
            if (!line_sel(use_rx)) stop_ok = 0;
        end
        msk = 8'((9'd1 << nb) - 9'd1);
        chk((got & msk) == (d & msk), req, "data bits (R1)", int'(got & msk), int'(d & msk));
        if (pe) chk(p == exp_par(d, wl, st, ev), st ? "R3" : "R2", "parity bit",
                    int'(p), int'(exp_par(d, wl, st, ev)));
        chk(stop_ok, s2 ? "R4" : "R1", "stop level", int'(stop_ok), 1);
    endtask

    task automatic send_check(input logic [7:0] d, input bit use_rx, input string req);
        push(d);
        frame_check(d, use_rx, c_wlen, c_pen, c_stp2, c_stick, c_eps, req);
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WDOG, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        apply_lcr();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        chk(txd_o == 1'b1, "R14", "idle line", int'(txd_o), 1);
        chk(ris_o == 1'b0, "R14", "ris after reset", int'(ris_o), 0);
        chk(fifo_rd_o == 1'b0, "R14", "no pop", int'(fifo_rd_o), 0);

        // R5 gating: block disabled, then tx disabled
        push(8'h5A);
        repeat (100) @(negedge clk);
        chk(wp - rp == 1 && txd_o, "R5", "no start with en=0", wp - rp, 1);
        ctl_en_i = 1'b1;
        repeat (100) @(negedge clk);
        chk(wp - rp == 1 && txd_o, "R5", "no start with txe=0", wp - rp, 1);
        ctl_txe_i = 1'b1;
        frame_check(8'h5A, 0, c_wlen, c_pen, c_stp2, c_stick, c_eps, "R5");
        wait_ticks(20);

        // R1..R4 random frames
        for (int n = 0; n < 40; n++) begin
            logic [7:0] d;
            d = 8'($urandom);
            c_wlen = 2'($urandom); c_pen = 1'($urandom); c_eps = 1'($urandom);
            c_stick = 1'($urandom); c_stp2 = 1'($urandom);
            apply_lcr();
            send_check(d, 0, "R1");
            wait_ticks(20);
        end

        // directed corner cases: 5-bit stick odd, 8-bit even all ones
        c_wlen = 2'd0; c_pen = 1; c_stick = 1; c_eps = 0; c_stp2 = 1; apply_lcr();
        send_check(8'h1F, 0, "R3");
        wait_ticks(20);
        c_wlen = 2'd3; c_pen = 1; c_stick = 0; c_eps = 1; c_stp2 = 0; apply_lcr();
        send_check(8'hFF, 0, "R2");
        wait_ticks(20);

        // R6 config captured at start
        c_wlen = 2'd3; c_pen = 0; c_stp2 = 0; c_stick = 0; apply_lcr();
        push(8'hC3);
        fork
            frame_check(8'hC3, 0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
            begin
                repeat (60) @(negedge clk);
                c_wlen = 2'd0; c_pen = 1; apply_lcr();
            end
        join
        wait_ticks(20);
        c_wlen = 2'd3; c_pen = 0; apply_lcr();

        // R5 enable drop mid character
        push(8'h96);
        push(8'h69);
        fork
            frame_check(8'h96, 0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
            begin
                repeat (60) @(negedge clk);
                ctl_txe_i = 1'b0;
            end
        join
        repeat (400) @(negedge clk);
        chk(wp - rp == 1, "R5", "second char held", wp - rp, 1);
        chk(txd_o == 1'b1, "R5", "idle after finish", int'(txd_o), 1);
        ctl_txe_i = 1'b1;
        frame_check(8'h69, 0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        wait_ticks(20);

        // R7 break, R8 flush
        push(8'h55);
        fork
            frame_check(8'h55, 0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
            begin
                repeat (60) @(negedge clk);
                c_brk = 1; apply_lcr();
            end
        join
        wait_ticks(24);
        chk(txd_o == 1'b0, "R7", "break low", int'(txd_o), 0);
        push(8'h3C);
        repeat (200) @(negedge clk);
        chk(wp - rp == 1, "R7", "no pop in break", wp - rp, 1);
        chk(txd_o == 1'b0, "R7", "break held", int'(txd_o), 0);
        flush_cnt = 0;
        c_fen = 0; apply_lcr();
        repeat (4) @(negedge clk);
        chk(wp == rp, "R8", "fifo flushed", wp - rp, 0);
        chk(flush_cnt == 1, "R8", "flush pulse cycles", flush_cnt, 1);
        c_fen = 1; c_brk = 0; apply_lcr();
        repeat (4) @(negedge clk);
        chk(txd_o == 1'b1, "R7", "line idle after break", int'(txd_o), 1);

        // R9 loopback
        ctl_lbe_i = 1'b1; rxd_i = 1'b0;
        low_cnt = 0; mon_en = 1;
        send_check(8'hA7, 1, "R9");
        wait_ticks(20);
        mon_en = 0;
        chk(low_cnt == 0, "R9", "pin low cycles in loopback", low_cnt, 0);
        ctl_lbe_i = 1'b0;
        @(negedge clk);
        chk(rx_int_o == 1'b0, "R9", "rx follows pin 0", int'(rx_int_o), 0);
        rxd_i = 1'b1;
        @(negedge clk);
        chk(rx_int_o == 1'b1, "R9", "rx follows pin 1", int'(rx_int_o), 1);

        // R11, R13 level mode
        ctl_eot_i = 1'b0;
        tx_lvl_hit_i = 1'b1;
        @(negedge clk);
        tx_lvl_hit_i = 1'b0;
        chk(ris_o == 1'b1, "R11", "ris from level", int'(ris_o), 1);
        ris_clr_i = 1'b1;
        @(negedge clk);
        ris_clr_i = 1'b0;
        chk(ris_o == 1'b0, "R13", "ris cleared", int'(ris_o), 0);
        ris_clr_i = 1'b1; tx_lvl_hit_i = 1'b1;
        @(negedge clk);
        ris_clr_i = 1'b0; tx_lvl_hit_i = 1'b0;
        chk(ris_o == 1'b1, "R13", "set wins over clear", int'(ris_o), 1);
        ris_clr_i = 1'b1;
        @(negedge clk);
        ris_clr_i = 1'b0;

        // R12 drained mode
        ctl_eot_i = 1'b1;
        tx_lvl_hit_i = 1'b1;
        repeat (4) @(negedge clk);
        tx_lvl_hit_i = 1'b0;
        chk(ris_o == 1'b0, "R12", "level ignored", int'(ris_o), 0);
        push(8'h81);
        push(8'h7E);
        frame_check(8'h81, 0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
        frame_check(8'h7E, 0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
        chk(ris_o == 1'b0, "R12", "not set before drain", int'(ris_o), 0);
        wait_ticks(12);
        chk(ris_o == 1'b1, "R12", "set after last stop", int'(ris_o), 1);
        ris_clr_i = 1'b1;
        @(negedge clk);
        ris_clr_i = 1'b0;
        ctl_eot_i = 1'b0;

        // R10 SIR encoding
        ctl_sir_i = 1'b1;
        repeat (2) @(negedge clk);
        chk(txd_o == 1'b0, "R10", "SIR idle low", int'(txd_o), 0);
        hi_cnt = 0; rise_cnt = 0; mon_en = 1;
        push(8'hA5);
        repeat (700) @(negedge clk);
        mon_en = 0;
        chk(rise_cnt == 5, "R10", "pulse count", rise_cnt, 5);
        chk(hi_cnt == 5 * 3 * OS_DIV, "R10", "pulse high cycles", hi_cnt, 5 * 3 * OS_DIV);
        ctl_sir_i = 1'b0;
        repeat (2) @(negedge clk);

        finish_run();
    end

endmodule